// File: doc/BRIEF.md
# NAND Identification and Status Responder

This block supplies the bytes a host reads back from a NAND flash device model after an identification request or a status request. It watches the command and address write cycles on the device bus and keeps a small status register. It then answers each host read strobe with the next byte of the pending response. The status register records the write-protect pin, a ready flag and an error flag.

An identification request returns four entries: the manufacturer code, the device code, a filler byte and a geometry byte. The geometry byte depends on whether the modelled part uses large or small pages and on the width of its data bus. A status request returns one byte, taken at the moment the command is written. Every later read repeats that byte until the host writes another command. With the wide-bus option enabled the data output is 16 bits wide, and each response byte sits in the low half with a zero high half.

Page data reads and the storage array belong to other blocks. The ready/busy output always reports ready, because no operation in this model takes time.

Top module: `nand_idstat_resp`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `dout` is zero. Reset clears status bits 0 to 5 and sets ready (bit 6), and `rb` is 1 at all times. A read strobe before any command returns zero.
- R2: The status byte has error at bit 0, plane flags at bits 1 to 4, bit 5 at zero, ready at bit 6, and at bit 7 the level of `wp_n` (1 when the pin is high). With no error it reads 0xC0 when `wp_n` is high and 0x40 when it is low.
- R3: A command cycle writes byte 0x90 (`we` with `cle` high, `ale` low, `ce_n` low), and an address cycle follows it (`we` with `ale` high). After that, successive read strobes return `MFR_CODE`, `DEV_CODE`, `FILL_CODE` and then the geometry byte. A read strobe between the command and the address cycle returns zero.
- R4: The geometry byte is 0x15 for a large-page part on an 8-bit bus, 0x55 for a large-page part on a 16-bit bus, and 0xC0 for a small-page part.
- R5: Once all four identification entries have been read, every further read strobe returns zero.
- R6: Command 0x70 captures the status byte present when it is written. Every read strobe after it returns that captured byte and consumes nothing, even if `wp_n` changes, until the next command cycle.
- R7: A read strobe with `ce_n` high returns zero and does not advance the identification sequence.
- R8: With `WIDE_BUS` set, `dout` is 16 bits and bits 15 to 8 are always zero.
- R9: Command 0xFF ends any pending response, so later reads return zero. It clears status bits 0 to 5 and keeps ready set.
- R10: Any other command byte ends the pending response, and later read strobes return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Marks a write cycle as a command |
| ale | input | 1 | Marks a write cycle as an address |
| we | input | 1 | Write strobe, one cycle per bus write |
| re | input | 1 | Read strobe, one cycle per bus read |
| wp_n | input | 1 | Write-protect pin, high means writes allowed |
| din | input | 8 | Command or address byte |
| dout | output | 8 or 16 (`WIDE_BUS`) | Registered read data, updated on each read strobe |
| rb | output | 1 | Ready/busy, held at 1 (ready) |

## Verification
The bench targets these corner cases:
- It moves `wp_n` during a status read sequence, to catch a design that samples the pin live instead of holding the captured byte.
- It reads before the address cycle of an identification request, and again after the fourth entry. A design that arms too early or wraps its pointer would return manufacturer codes there instead of zero.
- A read strobe with chip enable high sits between two identification reads. A design that advances on it would skip the device code.
- Three instances, with large-page narrow, large-page wide and small-page settings, expose a wrong geometry byte or a non-zero high half on the wide bus.

// File: rtl/nand_resp_pkg.sv
package nand_resp_pkg;
  localparam logic [7:0] OP_READ_ID   = 8'h90;
  localparam logic [7:0] OP_READ_STAT = 8'h70;
  localparam logic [7:0] OP_RESET     = 8'hFF;

  localparam int ID_LEN   = 4;
  localparam int ST_ERR   = 0;
  localparam int ST_READY = 6;
  localparam int ST_NWP   = 7;

  typedef enum logic [1:0] {
    RSP_IDLE,
    RSP_ID_ARM,
    RSP_ID,
    RSP_STAT
  } rsp_mode_t;
endpackage

// File: rtl/nand_status_reg.sv
module nand_status_reg
  import nand_resp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       soft_rst,
  input  logic       wp_n,
  output logic [7:0] stat
);
  logic [7:0] stat_q;

  // Bit 7 follows the pin every cycle; the rest only change on a reset.
  always_ff @(posedge clk) begin
    stat_q[ST_NWP] <= wp_n;
    if (rst || soft_rst) begin
      stat_q[ST_NWP-1:0] <= 7'(1 << ST_READY);
    end
  end

  assign stat = stat_q;

  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (stat[ST_READY] && stat[5:0] == 6'd0));

  assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (stat[ST_READY] && !stat[ST_ERR]));
endmodule

// File: rtl/nand_id_table.sv
module nand_id_table
  import nand_resp_pkg::*;
#(
  parameter logic [7:0] MFR_CODE   = 8'hEC,
  parameter logic [7:0] DEV_CODE   = 8'hF1,
  parameter logic [7:0] FILL_CODE  = 8'h51,
  parameter bit         LARGE_PAGE = 1'b1,
  parameter bit         WIDE_BUS   = 1'b0,
  parameter int         IDX_W      = 3
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       entry
);
  logic [7:0] geom;

  generate
    if (LARGE_PAGE) begin : g_large
      // bit 6 marks a 16-bit bus; other fields give page, block, spare size
      assign geom = WIDE_BUS ? 8'h55 : 8'h15;
    end else begin : g_small
      assign geom = 8'hC0;
    end
  endgenerate

  always_comb begin
    case (idx)
      IDX_W'(0): entry = MFR_CODE;
      IDX_W'(1): entry = DEV_CODE;
      IDX_W'(2): entry = FILL_CODE;
      IDX_W'(3): entry = geom;
      default:   entry = 8'h00;
    endcase
  end
endmodule

// File: rtl/nand_resp_seq.sv
module nand_resp_seq
  import nand_resp_pkg::*;
#(
  parameter int IO_W  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             we,
  input  logic             re,
  input  logic [7:0]       din,
  input  logic [7:0]       stat,
  input  logic [7:0]       id_entry,
  output logic [IDX_W-1:0] idx,
  output logic             soft_rst,
  output logic [IO_W-1:0]  dout
);
  rsp_mode_t        mode_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       snap_q;
  logic [IO_W-1:0]  dout_q;
  logic             cmd_wr, addr_wr, rd_ok;

  assign cmd_wr   = we && cle && !ale && !ce_n;
  assign addr_wr  = we && ale && !cle && !ce_n;
  assign rd_ok    = re && !ce_n;
  assign soft_rst = cmd_wr && (din == OP_RESET);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= RSP_IDLE;
      idx_q  <= '0;
      snap_q <= '0;
      dout_q <= '0;
    end else if (cmd_wr) begin
      idx_q <= '0;
      case (din)
        OP_READ_ID:   mode_q <= RSP_ID_ARM;
        OP_READ_STAT: begin
          mode_q <= RSP_STAT;
          snap_q <= stat;
        end
        default:      mode_q <= RSP_IDLE;
      endcase
    end else if (addr_wr) begin
      if (mode_q == RSP_ID_ARM) begin
        mode_q <= RSP_ID;
        idx_q  <= '0;
      end
    end else if (re) begin
      if (!rd_ok) begin
        dout_q <= '0;
      end else begin
        case (mode_q)
          RSP_ID: begin
            dout_q <= IO_W'(id_entry);
            if (idx_q < IDX_W'(ID_LEN)) idx_q <= idx_q + 1'b1;
          end
          RSP_STAT: dout_q <= IO_W'(snap_q);
          default:  dout_q <= '0;
        endcase
      end
    end
  end

  assign idx  = idx_q;
  assign dout = dout_q;

  logic st_rd;
  assign st_rd = (mode_q == RSP_STAT) && rd_ok && !cmd_wr && !addr_wr;

  assert_idx_bound_R5: assert property (@(posedge clk) disable iff (rst)
    idx_q <= IDX_W'(ID_LEN));

  assert_ce_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (re && ce_n) |=> (dout_q == '0));

  assert_status_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (st_rd ##1 st_rd) |=> $stable(dout_q));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == RSP_IDLE) && rd_ok && !cmd_wr && !addr_wr) |=> (dout_q == '0));
endmodule

// File: rtl/nand_idstat_resp.sv
module nand_idstat_resp
  import nand_resp_pkg::*;
#(
  parameter logic [7:0] MFR_CODE   = 8'hEC,
  parameter logic [7:0] DEV_CODE   = 8'hF1,
  parameter logic [7:0] FILL_CODE  = 8'h51,
  parameter bit         LARGE_PAGE = 1'b1,
  parameter bit         WIDE_BUS   = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ce_n,
  input  logic                          cle,
  input  logic                          ale,
  input  logic                          we,
  input  logic                          re,
  input  logic                          wp_n,
  input  logic [7:0]                    din,
  output logic [(WIDE_BUS ? 16 : 8)-1:0] dout,
  output logic                          rb
);
  localparam int IO_W  = WIDE_BUS ? 16 : 8;
  localparam int IDX_W = $clog2(ID_LEN + 1);

  logic [7:0]       stat;
  logic [7:0]       id_entry;
  logic [IDX_W-1:0] idx;
  logic             soft_rst;

  nand_status_reg u_stat (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .wp_n     (wp_n),
    .stat     (stat)
  );

  nand_id_table #(
    .MFR_CODE   (MFR_CODE),
    .DEV_CODE   (DEV_CODE),
    .FILL_CODE  (FILL_CODE),
    .LARGE_PAGE (LARGE_PAGE),
    .WIDE_BUS   (WIDE_BUS),
    .IDX_W      (IDX_W)
  ) u_id (
    .idx   (idx),
    .entry (id_entry)
  );

  nand_resp_seq #(
    .IO_W  (IO_W),
    .IDX_W (IDX_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .cle      (cle),
    .ale      (ale),
    .we       (we),
    .re       (re),
    .din      (din),
    .stat     (stat),
    .id_entry (id_entry),
    .idx      (idx),
    .soft_rst (soft_rst),
    .dout     (dout)
  );

  // No modelled operation takes time, so the part never reports busy.
  assign rb = 1'b1;

  generate
    if (IO_W > 8) begin : g_wide_chk
      assert_wide_pad_R8: assert property (@(posedge clk) disable iff (rst)
        dout[IO_W-1:8] == '0);
    end
  endgenerate
endmodule

// File: tb/nand_idstat_resp_test.sv
module nand_idstat_resp_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst, ce_n, cle, ale, we, re, wp_n;
  logic [7:0] din;
  logic [7:0]  d_lp;
  logic [15:0] d_wd;
  logic [7:0]  d_sp;
  logic        rb_lp, rb_wd, rb_sp;

  nand_idstat_resp uut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we(we),
    .re(re), .wp_n(wp_n), .din(din), .dout(d_lp), .rb(rb_lp));

  nand_idstat_resp #(.LARGE_PAGE(1'b1), .WIDE_BUS(1'b1)) uut_wide (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we(we),
    .re(re), .wp_n(wp_n), .din(din), .dout(d_wd), .rb(rb_wd));

  nand_idstat_resp #(.LARGE_PAGE(1'b0), .WIDE_BUS(1'b0)) uut_small (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we(we),
    .re(re), .wp_n(wp_n), .din(din), .dout(d_sp), .rb(rb_sp));

  typedef struct {
    logic [15:0] lp;
    logic [15:0] wd;
    logic [15:0] sp;
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(string req, string who, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, who, act, exp);
    end
  endtask

  // driver tasks: called at a falling edge, return at the next falling edge
  task automatic bus_cmd(logic [7:0] b);
    din = b; cle = 1'b1; we = 1'b1;
    @(negedge clk);
    cle = 1'b0; we = 1'b0;
  endtask

  task automatic bus_addr(logic [7:0] b);
    din = b; ale = 1'b1; we = 1'b1;
    @(negedge clk);
    ale = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] e_lp, logic [7:0] e_wd, logic [7:0] e_sp, string req);
    exp_t e;
    e.lp = {8'h00, e_lp};
    e.wd = {8'h00, e_wd};
    e.sp = {8'h00, e_sp};
    e.req = req;
    q.push_back(e);
    re = 1'b1;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic read_all(logic [7:0] e, string req);
    bus_read(e, e, e, req);
  endtask

  // monitor: dout is registered on the read edge, sample shortly after
  always @(posedge clk) begin
    if (re && !rst) begin
      #2;
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: actual=unexpected read expected=queued item");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.req, "uut", {8'h00, d_lp}, e.lp);
        chk({e.req, "/R8"}, "uut_wide", d_wd, e.wd);  // R8: high half zero
        chk(e.req, "uut_small", {8'h00, d_sp}, e.sp);
      end
    end
  end

  initial begin
    rst = 1'b1; ce_n = 1'b0; cle = 1'b0; ale = 1'b0; we = 1'b0; re = 1'b0;
    wp_n = 1'b1; din = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", "uut", {8'h00, d_lp}, 16'h0000);
    chk("R1", "uut_wide", d_wd, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "rb", {13'd0, rb_lp, rb_wd, rb_sp}, 16'h0007);
    read_all(8'h00, "R1");

    // R2 R6: status with write enabled, then sticky across a pin change
    bus_cmd(8'h70);
    read_all(8'hC0, "R2");
    read_all(8'hC0, "R6");
    wp_n = 1'b0;
    repeat (2) @(negedge clk);
    read_all(8'hC0, "R6");
    bus_cmd(8'h70);
    read_all(8'h40, "R2");
    read_all(8'h40, "R6");
    wp_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R4 R5: identification sequence
    bus_cmd(8'h90);
    read_all(8'h00, "R3");
    bus_addr(8'h00);
    read_all(8'hEC, "R3");
    read_all(8'hF1, "R3");
    read_all(8'h51, "R3");
    bus_read(8'h15, 8'h55, 8'hC0, "R4");
    read_all(8'h00, "R5");
    read_all(8'h00, "R5");

    // R7: read with chip disabled neither returns data nor advances
    bus_cmd(8'h90);
    bus_addr(8'h00);
    read_all(8'hEC, "R7");
    ce_n = 1'b1;
    read_all(8'h00, "R7");
    ce_n = 1'b0;
    read_all(8'hF1, "R7");

    // R10: unrelated command ends the response
    bus_cmd(8'h00);
    read_all(8'h00, "R10");

    // R9: reset command ends the response and keeps ready
    bus_cmd(8'h90);
    bus_addr(8'h00);
    read_all(8'hEC, "R9");
    bus_cmd(8'hFF);
    read_all(8'h00, "R9");
    bus_cmd(8'h70);
    read_all(8'hC0, "R9");

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: actual=%0d left expected=0", q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule